// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of an integrating analog-to-digital converter. It controls the analog switches around an external integrator and reads the single comparator bit that watches the integrator output. A conversion runs in a fixed order. The integrator is first cleared. The unknown input is then applied for a fixed number of clock ticks. The switch then moves to the negative reference, and the block times how long the integrator takes to return to zero.

The discharge rate is fixed. Because of that, the measured discharge time is proportional to the charge collected from the input, and that count is the conversion result. If the comparator never trips before the time-base counter is full, the block flags an overrange and returns the full-scale code. A one-cycle completion pulse marks each new result. The result stays in place until the next conversion completes.

Top module: `dual_slope_seq`

## Requirements
- R1: After reset, `intReset`, `selInput`, `selNegRef`, `busy`, `done` and `overrange` are 0, and `result` is 0.
- R2: A `startReq` seen in idle starts a conversion. `intReset` is then high for exactly RST_TICKS consecutive cycles, and during those cycles `selInput` and `selNegRef` are both 0.
- R3: Directly after the clearing phase, `selInput` is high for exactly INT_TICKS consecutive cycles.
- R4: Directly after the input phase, `selNegRef` is high until the comparator trips or the counter is full. `selInput` and `selNegRef` are never high together.
- R5: The discharge counter starts at 0 in the first cycle of the reference phase. It advances by one in each cycle in which `cmpAtZero` (1 = integrator at or below zero) is low. When `cmpAtZero` is high, the current count is captured as `result`, so `result` is one less than the number of cycles `selNegRef` was high.
- R6: If the counter holds its maximum 2^CNT_W-1 and `cmpAtZero` is still low, the conversion ends with `overrange`=1 and `result` all ones. A conversion ended by the comparator sets `overrange`=0.
- R7: `done` is high for exactly one cycle per conversion. It is high in the first cycle in which the new `result` and `overrange` are visible, and the block is idle in the following cycle.
- R8: `result` and `overrange` change only in a cycle in which `done` is high. They hold their values between conversions, whatever the comparator input does.
- R9: `startReq` is ignored while a conversion is running. It neither restarts the clearing phase nor causes a second conversion.
- R10: `busy` is high from the cycle after the accepted `startReq` through the `done` cycle, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request a conversion (taken only when idle) |
| cmpAtZero | input | 1 | Comparator: 1 when integrator output is at or below zero |
| intReset | output | 1 | Closes the integrator-clearing switch |
| selInput | output | 1 | Connects the unknown input to the integrator |
| selNegRef | output | 1 | Connects the negative reference to the integrator |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse: new result available |
| overrange | output | 1 | Last conversion exceeded the counter range |
| result | output | CNT_W | Last conversion code |

## Verification
The assertions assume that `cmpAtZero` comes from a real integrator. It may do anything outside the reference phase, and the sequencer only samples it during that phase. The properties on switch exclusivity, phase order and result holding therefore place no constraint on the comparator's value. The bench drives the comparator from a discrete integrator model that is updated on the falling clock edge from the switch outputs. It changes the integrator model's input level only between conversions. Tests that probe the hold behaviour deliberately leave the comparator low or toggle it while idle.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CLEAR  = 3'd1,
    ST_CHARGE = 3'd2,
    ST_DRAIN  = 3'd3,
    ST_FINISH = 3'd4
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntClear;   // counter to zero
    logic cntStep;    // counter + 1
    logic capCount;   // latch counter as result, clear overrange
    logic capFull;    // latch full-scale result, set overrange
  } dpCtrl_t;

endpackage

// File: rtl/dsadc_datapath.sv
module dsadc_datapath
  import dsadc_pkg::*;
#(
  parameter int unsigned CNT_W     = 10,
  parameter int unsigned INT_TICKS = 256,
  parameter int unsigned RST_TICKS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctrl,
  output logic             clearLast,
  output logic             chargeLast,
  output logic             cntFull,
  output logic [CNT_W-1:0] resultQ,
  output logic             overQ
);

  localparam logic [CNT_W-1:0] CHARGE_END = CNT_W'(INT_TICKS - 1);
  localparam logic [CNT_W-1:0] FULL_CODE  = {CNT_W{1'b1}};

  logic [CNT_W-1:0] tick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tick <= '0;
    end else if (ctrl.cntClear) begin
      tick <= '0;
    end else if (ctrl.cntStep) begin
      tick <= tick + 1'b1;
    end
  end

  // Clearing-phase terminal count: a single-tick clear needs no compare
  generate
    if (RST_TICKS <= 1) begin : g_clearOne
      assign clearLast = 1'b1;
    end else begin : g_clearCmp
      localparam logic [CNT_W-1:0] CLEAR_END = CNT_W'(RST_TICKS - 1);
      assign clearLast = (tick == CLEAR_END);
    end
  endgenerate

  assign chargeLast = (tick == CHARGE_END);
  assign cntFull    = (tick == FULL_CODE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ <= '0;
      overQ   <= 1'b0;
    end else if (ctrl.capCount) begin
      resultQ <= tick;
      overQ   <= 1'b0;
    end else if (ctrl.capFull) begin
      resultQ <= FULL_CODE;
      overQ   <= 1'b1;
    end
  end

endmodule

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl
  import dsadc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    cmpAtZero,
  input  logic    clearLast,
  input  logic    chargeLast,
  input  logic    cntFull,
  output dpCtrl_t ctrl,
  output logic    intReset,
  output logic    selInput,
  output logic    selNegRef,
  output logic    busy,
  output logic    done
);

  seqState_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    ctrl   = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (startReq) begin
          stateD        = ST_CLEAR;
          ctrl.cntClear = 1'b1;
        end
      end
      ST_CLEAR: begin
        if (clearLast) begin
          stateD        = ST_CHARGE;
          ctrl.cntClear = 1'b1;
        end else begin
          ctrl.cntStep = 1'b1;
        end
      end
      ST_CHARGE: begin
        if (chargeLast) begin
          stateD        = ST_DRAIN;
          ctrl.cntClear = 1'b1;
        end else begin
          ctrl.cntStep = 1'b1;
        end
      end
      ST_DRAIN: begin
        if (cmpAtZero) begin
          stateD        = ST_FINISH;
          ctrl.capCount = 1'b1;
        end else if (cntFull) begin
          stateD       = ST_FINISH;
          ctrl.capFull = 1'b1;
        end else begin
          ctrl.cntStep = 1'b1;
        end
      end
      ST_FINISH: stateD = ST_IDLE;
      default:   stateD = ST_IDLE;
    endcase
  end

  assign intReset  = (stateQ == ST_CLEAR);
  assign selInput  = (stateQ == ST_CHARGE);
  assign selNegRef = (stateQ == ST_DRAIN);
  assign done      = (stateQ == ST_FINISH);
  assign busy      = (stateQ != ST_IDLE);

endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import dsadc_pkg::*;
#(
  parameter int unsigned CNT_W     = 10,
  parameter int unsigned INT_TICKS = 256,
  parameter int unsigned RST_TICKS = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             cmpAtZero,
  output logic             intReset,
  output logic             selInput,
  output logic             selNegRef,
  output logic             busy,
  output logic             done,
  output logic             overrange,
  output logic [CNT_W-1:0] result
);

  dpCtrl_t ctrl;
  logic    clearLast, chargeLast, cntFull;

  dsadc_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .cmpAtZero  (cmpAtZero),
    .clearLast  (clearLast),
    .chargeLast (chargeLast),
    .cntFull    (cntFull),
    .ctrl       (ctrl),
    .intReset   (intReset),
    .selInput   (selInput),
    .selNegRef  (selNegRef),
    .busy       (busy),
    .done       (done)
  );

  dsadc_datapath #(
    .CNT_W     (CNT_W),
    .INT_TICKS (INT_TICKS),
    .RST_TICKS (RST_TICKS)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .clearLast  (clearLast),
    .chargeLast (chargeLast),
    .cntFull    (cntFull),
    .resultQ    (result),
    .overQ      (overrange)
  );

endmodule

// File: rtl/dsadc_chk.sv
module dsadc_chk #(
  parameter int unsigned CNT_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             intReset,
  input logic             selInput,
  input logic             selNegRef,
  input logic             busy,
  input logic             done,
  input logic             overrange,
  input logic [CNT_W-1:0] result
);

  AST_SWITCH_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $countones({intReset, selInput, selNegRef}) <= 1);  // R4

  AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    intReset |-> (!selInput && !selNegRef));  // R2

  AST_CLEAR_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intReset) |-> !$past(busy));  // R2

  AST_CHARGE_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selInput) |-> $past(intReset));  // R3

  AST_DRAIN_AFTER_CHARGE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selNegRef) |-> $past(selInput));  // R4

  AST_OVR_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (done && overrange) |-> (result == {CNT_W{1'b1}}));  // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));  // R7

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(result) && $stable(overrange)));  // R8

  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);  // R10

endmodule

bind dual_slope_seq dsadc_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .intReset  (intReset),
  .selInput  (selInput),
  .selNegRef (selNegRef),
  .busy      (busy),
  .done      (done),
  .overrange (overrange),
  .result    (result)
);

// File: tb/dual_slope_seq_tb_top.sv
`timescale 1ns/1ps
module dual_slope_seq_tb_top;

  localparam int CNT_W     = 10;
  localparam int INT_TICKS = 256;
  localparam int RST_TICKS = 4;
  localparam int VREF      = 256;
  localparam int FULL      = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic cmpAtZero = 1'b0;
  logic intReset, selInput, selNegRef, busy, done, overrange;
  logic [CNT_W-1:0] result;

  always #10 clk = ~clk;  // 50 MHz

  dual_slope_seq #(
    .CNT_W(CNT_W), .INT_TICKS(INT_TICKS), .RST_TICKS(RST_TICKS)
  ) dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .cmpAtZero(cmpAtZero),
    .intReset(intReset), .selInput(selInput), .selNegRef(selNegRef),
    .busy(busy), .done(done), .overrange(overrange), .result(result)
  );

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // Integrator model and phase monitors
  longint vInt = 0;
  int     vin = 0;
  bit     modelOn = 1'b1;
  int nClear, nCharge, nDrain, nDone, nBusyBad;
  bit seenClear, seenCharge;
  bit orderBad;

  always @(negedge clk) begin
    cycles++;
    if (intReset)       vInt = 0;
    else if (selInput)  vInt = vInt + vin;
    else if (selNegRef) vInt = vInt - VREF;
    if (modelOn) cmpAtZero <= (vInt <= 0);
    if (intReset) begin nClear++; seenClear = 1'b1; if (seenCharge) orderBad = 1'b1; end
    if (selInput) begin nCharge++; seenCharge = 1'b1; if (!seenClear) orderBad = 1'b1; end
    if (selNegRef) begin nDrain++; if (!seenCharge) orderBad = 1'b1; end
    if (done) nDone++;
    if ((intReset || selInput || selNegRef || done) && !busy) nBusyBad++;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearMon();
    nClear = 0; nCharge = 0; nDrain = 0; nDone = 0; nBusyBad = 0;
    seenClear = 0; seenCharge = 0; orderBad = 0;
  endtask

  task automatic waitDone(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk); #1;
      if (done) begin ok = 1'b1; break; end
    end
    if (!ok) check(1'b0, "watchdog", 0, 1);
  endtask

  task automatic pulseStart();
    @(negedge clk); #1;
    startReq = 1'b1;
    @(negedge clk); #1;
    startReq = 1'b0;
    check(busy === 1'b1, "R10 busy after start", busy, 1);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check({intReset, selInput, selNegRef, busy, done, overrange} === 6'b0, "R1 outputs",
          {intReset, selInput, selNegRef, busy, done, overrange}, 0);
    check(result === '0, "R1 result", result, 0);
    rstN = 1'b1;
  endtask

  // One full conversion with an input level, checked against the model
  task automatic runConv(input int level);
    longint k;
    bit expOvr, ok;
    int expRes;
    vin = level;
    clearMon();
    k = (longint'(level) * INT_TICKS + VREF - 1) / VREF - 1;
    if (k < 0) k = 0;
    expOvr = (k > FULL);
    expRes = expOvr ? FULL : int'(k);
    pulseStart();
    waitDone(ok);
    if (!ok) return;
    check(nClear == RST_TICKS, "R2 clear length", nClear, RST_TICKS);
    check(nCharge == INT_TICKS, "R3 charge length", nCharge, INT_TICKS);
    check(!orderBad, "R4 phase order", orderBad, 0);
    check(result == expRes, "R5 result", result, expRes);
    if (!expOvr) check(int'(result) == nDrain - 1, "R5 drain count", result, nDrain - 1);
    check(overrange == expOvr, "R6 overrange", overrange, expOvr);
    check(busy === 1'b1, "R10 busy at done", busy, 1);
    @(negedge clk); #1;
    check(done === 1'b0 && nDone == 1, "R7 done pulse", nDone, 1);
    check(busy === 1'b0, "R10 idle after done", busy, 0);
  endtask

  // Result and flag hold while idle and the comparator moves
  task automatic testHold();
    logic [CNT_W-1:0] r0;
    logic o0;
    r0 = result; o0 = overrange;
    modelOn = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1;
      cmpAtZero = i[0];
    end
    check(result == r0, "R8 result hold", result, r0);
    check(overrange == o0, "R8 overrange hold", overrange, o0);
    check(busy === 1'b0, "R8 stays idle", busy, 0);
    modelOn = 1'b1;
  endtask

  // Start pulses during a running conversion must not restart it
  task automatic testIgnoreStart();
    bit ok;
    vin = 10;
    clearMon();
    pulseStart();
    repeat (2) @(negedge clk);
    #1; startReq = 1'b1;
    repeat (RST_TICKS + 20) @(negedge clk);
    #1; startReq = 1'b0;
    waitDone(ok);
    if (!ok) return;
    check(nClear == RST_TICKS, "R9 no restart of clear", nClear, RST_TICKS);
    check(nCharge == INT_TICKS, "R9 charge unaffected", nCharge, INT_TICKS);
    check(result == 9, "R9 result", result, 9);
    clearMon();
    repeat (10) @(negedge clk);
    #1;
    check(nClear == 0 && busy === 1'b0, "R9 no second conversion", nClear, 0);
  endtask

  initial begin
    testReset();
    runConv(37);
    runConv(0);
    runConv(1);
    runConv(500);
    runConv(1024);
    runConv(1025);
    testHold();
    runConv(2000);
    testHold();
    runConv(77);
    testIgnoreStart();
    check(nBusyBad == 0, "R10 busy coverage", nBusyBad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 190000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<190000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule